// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two component predictors and an arbiter for each entry. The local component is a table of saturating counters that is addressed only by the branch address. The correlating component adds a short global history of recent resolved outcomes to the address. That history picks one counter from a group of 2^m counters that belongs to the addressed entry. A 2-bit arbiter for each entry decides which component drives the final guess. The arbiter moves only when exactly one of the two components was right.

A fetch stage presents a PC on the lookup side. In the same cycle it gets back the final guess, both component guesses and the history value that was used. When the branch resolves, the pipeline presents the update side with the PC, the real outcome, the two component guesses and the history that it captured at lookup. The block trains the local counter, trains the correlating counter that history picked, steps the arbiter and shifts the outcome into the global history. The table index starts at PC bit 2, and the number of index bits is a parameter.

Top module: `tourney_bp`

## Requirements
- R1: The entry index is PC bits [2 +: IDX_W]. PC bits 1:0 and all bits above the index have no effect on which entry is read or written.
- R2: After reset every direction counter holds the weakly-not-taken value 2^(CNT_W-1)-1. Every arbiter holds 1 (weakly prefer local) and the global history is 0, so all lookups return not-taken with lkHist = 0.
- R3: Direction counters saturate at 0 and 2^CNT_W-1 and predict taken when their MSB is 1. From the strongly-taken state, one not-taken outcome leaves the guess taken and a second one flips it.
- R4: The global history changes only on an accepted update. The new outcome enters at bit 0 and older bits move up, so taken followed by not-taken gives binary 10. lkHist shows the current history.
- R5: The correlating counter is selected by {index, history}. An update trains only the counter selected by upHist, and the other counters of that entry keep their values.
- R6: The arbiter is a 2-bit saturating value from 0 to 3. Values 2 and 3 select the correlating guess and values 0 and 1 select the local guess. It steps up when only the correlating guess was right, steps down when only the local guess was right, and holds when both or neither were right.
- R7: lkTaken equals lkCorrPred when the indexed arbiter selects correlating and lkLocalPred otherwise.
- R8: A lookup and an update in the same cycle return the values held before that update. The update takes effect from the next cycle.
- R9: Every accepted update trains the local counter of the indexed entry toward the outcome, whatever the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkPc | input | PC_W | Lookup branch address |
| lkTaken | output | 1 | Final direction guess |
| lkLocalPred | output | 1 | Local component guess |
| lkCorrPred | output | 1 | Correlating component guess |
| lkHist | output | HIST_W | Global history used for this lookup |
| upValid | input | 1 | Update strobe |
| upPc | input | PC_W | Resolved branch address |
| upTaken | input | 1 | Resolved outcome |
| upLocalPred | input | 1 | Local guess given at lookup |
| upCorrPred | input | 1 | Correlating guess given at lookup |
| upHist | input | HIST_W | History value returned at lookup |

## Verification
The hardest state to reach from the ports is an arbiter that sits in a given position while the local and correlating guesses for the same entry disagree. Only then does lkTaken show which component was chosen. To get there, the bench runs a long pseudo-random stream of updates over a small configuration of 8 entries with 2 history bits. Random high and low PC bits alias onto the same entries, and the component guesses it feeds back are sometimes inverted. This drives the arbiter through its both-right, both-wrong and one-right cases. After every update, an arithmetic reference model checks every entry. Directed sequences cover the saturation, history-order and same-cycle cases with fixed expected constants.

// File: rtl/bpPkg.sv
`timescale 1ns/1ps
package bpPkg;
  localparam int IDX_LO = 2;
  localparam int CHOOSE_W = 2;
  localparam logic [CHOOSE_W-1:0] CHOOSE_RESET = 2'd1;

  typedef struct packed {
    logic trainEn;
    logic outcome;
    logic toCorr;
    logic toLocal;
  } bpStrobe_t;
endpackage

// File: rtl/bpControl.sv
`timescale 1ns/1ps
module bpControl
  import bpPkg::*;
(
  input  logic      upValid,
  input  logic      upTaken,
  input  logic      upLocalPred,
  input  logic      upCorrPred,
  input  logic      lkLocalPred,
  input  logic      lkCorrPred,
  input  logic      lkChooseCorr,
  output bpStrobe_t stb,
  output logic      lkTaken
);
  logic localOk;
  logic corrOk;

  assign localOk = (upLocalPred == upTaken);
  assign corrOk  = (upCorrPred == upTaken);

  always_comb begin
    stb.trainEn = upValid;
    stb.outcome = upTaken;
    stb.toCorr  = upValid & corrOk & ~localOk;
    stb.toLocal = upValid & localOk & ~corrOk;
  end

  assign lkTaken = lkChooseCorr ? lkCorrPred : lkLocalPred;
endmodule

// File: rtl/bpDatapath.sv
`timescale 1ns/1ps
module bpDatapath
  import bpPkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lkIdx,
  input  logic [IDX_W-1:0]  upIdx,
  input  logic [HIST_W-1:0] upHist,
  input  bpStrobe_t         stb,
  output logic              lkLocalPred,
  output logic              lkCorrPred,
  output logic              lkChooseCorr,
  output logic [HIST_W-1:0] histQ
);
  localparam int ENTRIES  = 1 << IDX_W;
  localparam int CORR_N   = ENTRIES << HIST_W;
  localparam int CIDX_W   = IDX_W + HIST_W;
  localparam logic [CNT_W-1:0] CNT_RESET = (CNT_W)'((1 << (CNT_W - 1)) - 1);

  logic [CNT_W-1:0]    localTbl  [ENTRIES];
  logic [CNT_W-1:0]    corrTbl   [CORR_N];
  logic [CHOOSE_W-1:0] chooseTbl [ENTRIES];
  logic [HIST_W-1:0]   histNext;
  logic [CIDX_W-1:0]   lkCorrIdx;
  logic [CIDX_W-1:0]   upCorrIdx;

  function automatic logic [CNT_W-1:0] stepCnt(input logic [CNT_W-1:0] v, input logic up);
    if (up && (v != {CNT_W{1'b1}}))      return v + 1'b1;
    else if (!up && (v != '0))           return v - 1'b1;
    else                                 return v;
  endfunction

  function automatic logic [CHOOSE_W-1:0] stepChoose(input logic [CHOOSE_W-1:0] v,
                                                     input logic inc, input logic dec);
    if (inc && (v != {CHOOSE_W{1'b1}}))  return v + 1'b1;
    else if (dec && (v != '0))           return v - 1'b1;
    else                                 return v;
  endfunction

  generate
    if (HIST_W == 1) begin : gHistOne
      assign histNext = stb.outcome;
    end else begin : gHistMany
      assign histNext = {histQ[HIST_W-2:0], stb.outcome};
    end
  endgenerate

  assign lkCorrIdx = {lkIdx, histQ};
  assign upCorrIdx = {upIdx, upHist};

  assign lkLocalPred  = localTbl[lkIdx][CNT_W-1];
  assign lkCorrPred   = corrTbl[lkCorrIdx][CNT_W-1];
  assign lkChooseCorr = chooseTbl[lkIdx][CHOOSE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        localTbl[i]  <= CNT_RESET;
        chooseTbl[i] <= CHOOSE_RESET;
      end
      histQ <= '0;
    end else if (stb.trainEn) begin
      localTbl[upIdx]  <= stepCnt(localTbl[upIdx], stb.outcome);
      chooseTbl[upIdx] <= stepChoose(chooseTbl[upIdx], stb.toCorr, stb.toLocal);
      histQ            <= histNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CORR_N; i++) corrTbl[i] <= CNT_RESET;
    end else if (stb.trainEn) begin
      corrTbl[upCorrIdx] <= stepCnt(corrTbl[upCorrIdx], stb.outcome);
    end
  end
endmodule

// File: rtl/tourney_bp.sv
`timescale 1ns/1ps
module tourney_bp
  import bpPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lkPc,
  output logic              lkTaken,
  output logic              lkLocalPred,
  output logic              lkCorrPred,
  output logic [HIST_W-1:0] lkHist,
  input  logic              upValid,
  input  logic [PC_W-1:0]   upPc,
  input  logic              upTaken,
  input  logic              upLocalPred,
  input  logic              upCorrPred,
  input  logic [HIST_W-1:0] upHist
);
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  bpStrobe_t        stb;
  logic             lkChooseCorr;
  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] upIdx;
  logic             unusedPcBits;

  assign lkIdx = lkPc[IDX_HI:IDX_LO];
  assign upIdx = upPc[IDX_HI:IDX_LO];
  assign unusedPcBits = ^{lkPc[PC_W-1:IDX_HI+1], lkPc[IDX_LO-1:0],
                          upPc[PC_W-1:IDX_HI+1], upPc[IDX_LO-1:0]};

  bpControl uCtrl (
    .upValid      (upValid),
    .upTaken      (upTaken),
    .upLocalPred  (upLocalPred),
    .upCorrPred   (upCorrPred),
    .lkLocalPred  (lkLocalPred),
    .lkCorrPred   (lkCorrPred),
    .lkChooseCorr (lkChooseCorr),
    .stb          (stb),
    .lkTaken      (lkTaken)
  );

  bpDatapath #(.IDX_W(IDX_W), .HIST_W(HIST_W), .CNT_W(CNT_W)) uPath (
    .clk          (clk),
    .rst_n        (rst_n),
    .lkIdx        (lkIdx),
    .upIdx        (upIdx),
    .upHist       (upHist),
    .stb          (stb),
    .lkLocalPred  (lkLocalPred),
    .lkCorrPred   (lkCorrPred),
    .lkChooseCorr (lkChooseCorr),
    .histQ        (lkHist)
  );
endmodule

// File: rtl/bpChecker.sv
`timescale 1ns/1ps
module bpChecker #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   lkPc,
  input logic              lkTaken,
  input logic              lkLocalPred,
  input logic              lkCorrPred,
  input logic [HIST_W-1:0] lkHist,
  input logic              upValid,
  input logic              upTaken
);
  assert_agree_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lkLocalPred == lkCorrPred) |-> (lkTaken == lkLocalPred));

  assert_hist_newest_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upValid |=> (lkHist[0] == $past(upTaken)));

  assert_hist_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upValid |=> $stable(lkHist));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upValid ##1 $stable(lkPc) |-> ($stable(lkTaken) && $stable(lkLocalPred) && $stable(lkCorrPred)));
endmodule

bind tourney_bp bpChecker #(.PC_W(PC_W), .HIST_W(HIST_W)) uChk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lkPc        (lkPc),
  .lkTaken     (lkTaken),
  .lkLocalPred (lkLocalPred),
  .lkCorrPred  (lkCorrPred),
  .lkHist      (lkHist),
  .upValid     (upValid),
  .upTaken     (upTaken)
);

// File: tb/sim_tourney_bp.sv
`timescale 1ns/1ps
module sim_tourney_bp;
  localparam int PC_W = 32;
  localparam int IDX_W = 3;
  localparam int HIST_W = 2;
  localparam int CNT_W = 2;
  localparam int ENT = 1 << IDX_W;
  localparam int HN = 1 << HIST_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lkPc = '0;
  logic lkTaken, lkLocalPred, lkCorrPred;
  logic [HIST_W-1:0] lkHist;
  logic upValid = 1'b0;
  logic [PC_W-1:0] upPc = '0;
  logic upTaken = 1'b0, upLocalPred = 1'b0, upCorrPred = 1'b0;
  logic [HIST_W-1:0] upHist = '0;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  int mLoc [ENT];
  int mCor [ENT*HN];
  int mCh  [ENT];
  int mHist;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .lkPc(lkPc), .lkTaken(lkTaken),
    .lkLocalPred(lkLocalPred), .lkCorrPred(lkCorrPred), .lkHist(lkHist),
    .upValid(upValid), .upPc(upPc), .upTaken(upTaken),
    .upLocalPred(upLocalPred), .upCorrPred(upCorrPred), .upHist(upHist));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int idxOf(input logic [PC_W-1:0] pc);
    return int'(pc[2 +: IDX_W]);
  endfunction

  function automatic int expLocal(input logic [PC_W-1:0] pc);
    return (mLoc[idxOf(pc)] >= 2) ? 1 : 0;
  endfunction

  function automatic int expCorr(input logic [PC_W-1:0] pc);
    return (mCor[idxOf(pc)*HN + mHist] >= 2) ? 1 : 0;
  endfunction

  function automatic int expTaken(input logic [PC_W-1:0] pc);
    return (mCh[idxOf(pc)] >= 2) ? expCorr(pc) : expLocal(pc);
  endfunction

  function automatic int sat(input int v, input bit up);
    if (up) return (v < 3) ? v + 1 : 3;
    return (v > 0) ? v - 1 : 0;
  endfunction

  task automatic modelUpdate(input logic [PC_W-1:0] pc, input bit t, input bit lp, input bit cp);
    int i;
    i = idxOf(pc);
    mLoc[i] = sat(mLoc[i], t);
    mCor[i*HN + mHist] = sat(mCor[i*HN + mHist], t);
    if ((cp == t) && (lp != t)) mCh[i] = (mCh[i] < 3) ? mCh[i] + 1 : 3;
    if ((lp == t) && (cp != t)) mCh[i] = (mCh[i] > 0) ? mCh[i] - 1 : 0;
    mHist = ((mHist << 1) | int'(t)) & (HN - 1);
  endtask

  task automatic doUpdate(input logic [PC_W-1:0] pc, input bit t, input bit lp, input bit cp);
    @(negedge clk);
    upPc = pc; upTaken = t; upLocalPred = lp; upCorrPred = cp;
    upHist = HIST_W'(mHist); upValid = 1'b1;
    @(posedge clk);
    #1;
    upValid = 1'b0;
    modelUpdate(pc, t, lp, cp);
  endtask

  task automatic look(input logic [PC_W-1:0] pc);
    lkPc = pc;
    #1;
  endtask

  task automatic checkAll(input logic [PC_W-1:0] hiBits);
    for (int e = 0; e < ENT; e++) begin
      logic [PC_W-1:0] pc;
      pc = hiBits | (PC_W'(e) << 2);
      look(pc);
      chk("R9 local", 32'(lkLocalPred), 32'(expLocal(pc)));
      chk("R5 corr", 32'(lkCorrPred), 32'(expCorr(pc)));
      chk("R6 R7 final", 32'(lkTaken), 32'(expTaken(pc)));
    end
    chk("R4 hist", 32'(lkHist), 32'(mHist));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin mLoc[i] = 1; mCh[i] = 1; end
    for (int i = 0; i < ENT*HN; i++) mCor[i] = 1;
    mHist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R2: reset state
    for (int e = 0; e < ENT; e++) begin
      look(PC_W'(e) << 2);
      chk("R2 local", 32'(lkLocalPred), 0);
      chk("R2 corr", 32'(lkCorrPred), 0);
      chk("R2 final", 32'(lkTaken), 0);
    end
    chk("R2 hist", 32'(lkHist), 0);

    // R3/R1/R5: entry 5 at pc 0x14
    doUpdate(32'h14, 1, 0, 0);
    look(32'h14);
    chk("R3 weak to taken", 32'(lkLocalPred), 1);
    chk("R5 other hist untouched", 32'(lkCorrPred), 0);
    look(32'h14 | 32'h20 | 32'h3);
    chk("R1 alias high and low bits", 32'(lkLocalPred), 1);
    look(32'h10);
    chk("R1 neighbour untouched", 32'(lkLocalPred), 0);
    doUpdate(32'h14, 1, 1, 0);
    doUpdate(32'h14, 1, 1, 0);
    doUpdate(32'h14, 0, 1, 0);
    look(32'h14);
    chk("R3 one miss keeps taken", 32'(lkLocalPred), 1);
    doUpdate(32'h14, 0, 1, 0);
    look(32'h14);
    chk("R3 second miss flips", 32'(lkLocalPred), 0);
    chk("R4 hist after NN", 32'(lkHist), 0);
    doUpdate(32'h08, 1, 0, 0);
    doUpdate(32'h08, 0, 0, 0);
    chk("R4 taken then not-taken is 10", 32'(lkHist), 2);
    checkAll('0);

    // R8: same-cycle lookup and update
    @(negedge clk);
    lkPc = 32'h14;
    upPc = 32'h14; upTaken = 1'b1; upLocalPred = 1'b0; upCorrPred = 1'b0;
    upHist = HIST_W'(mHist); upValid = 1'b1;
    #1;
    chk("R8 pre-update local", 32'(lkLocalPred), 32'(expLocal(32'h14)));
    chk("R8 pre-update hist", 32'(lkHist), 32'(mHist));
    @(posedge clk);
    #1;
    upValid = 1'b0;
    modelUpdate(32'h14, 1, 0, 0);
    #1;
    chk("R8 post-update local", 32'(lkLocalPred), 32'(expLocal(32'h14)));
    checkAll(32'h100);

    // R5 R6 R7 R9 R1: pseudo-random sweep with aliasing PCs and perturbed guesses
    for (int n = 0; n < 1500; n++) begin
      logic [PC_W-1:0] pc;
      bit t, lp, cp;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pc = {16'h0, lfsr[15:8], lfsr[7:0]};
      t  = lfsr[3] ^ lfsr[9] ^ (idxOf(pc) < 4 ? 1'b1 : lfsr[11]);
      lp = 1'(expLocal(pc)) ^ (lfsr[5] & lfsr[6]);
      cp = 1'(expCorr(pc)) ^ (lfsr[12] & lfsr[14]);
      doUpdate(pc, t, lp, cp);
      checkAll({16'h0, lfsr[15:13], 13'h0} | PC_W'(lfsr[1:0]));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule